// File: doc/BRIEF.md
# UART Frame Transmitter

This block turns characters into asynchronous serial frames on a single output line. It runs on a clock at sixteen times the bit rate, so each bit lasts sixteen clocks. A character written to the block waits in a one-entry holding register. As soon as the shift engine is free, the character moves into the shift engine. The engine then sends a low start bit, the data bits with the least significant first, an optional parity bit and a high stop period. The line sits high between frames.

A small control word sets the frame shape. It selects a word length of 5 to 8 bits, one of five parity modes, and a short or long stop period. The long stop period lasts one and a half bits for 5-bit words and two bits for all other lengths. A break input forces the line low for as long as it is held. Two flags report state: one shows that the holding register can take a new character, and the other shows that the holding register and the shift engine are both empty.

Top module: `uart_tx_core`

## Requirements
- R1: While rst_n is low, and in the cycle after reset releases, txd is 1 (unless brk is 1), hold_empty is 1 and tx_empty is 1.
- R2: A frame starts the cycle after the holding register transfers to the shift engine. It starts with 16 clocks at 0. Whenever no frame is in flight, the line is 1.
- R3: word_len codes 00, 01, 10 and 11 give 5, 6, 7 and 8 data bits. The bits go out least significant first, and each bit lasts 16 clocks.
- R4: The parity bit is decoded from par_en, par_even and par_stick. With par_en=0 there is no parity bit. With par_stick=0, par_even=0 gives odd parity and par_even=1 gives even parity over the data bits sent. With par_stick=1, par_even=0 sends a constant 1 and par_even=1 sends a constant 0. The parity bit lasts 16 clocks.
- R5: The stop period is at 1. It lasts 16 clocks when stop_long=0, 24 clocks when stop_long=1 with a 5-bit word, and 32 clocks when stop_long=1 with any other word length.
- R6: A write (wr_en=1 at a clock edge) clears hold_empty after that edge. When the holding register is full and the shift engine is idle or in its last stop clock, the character moves to the engine at that edge, and hold_empty becomes 1 unless a write arrives at the same edge. Back-to-back frames therefore have no idle gap.
- R7: While brk is 1, txd is 0. Frame timing goes on underneath unchanged, and the line returns to the frame level once brk falls.
- R8: tx_empty is 1 exactly when the holding register is empty and no frame is in flight.
- R9: A write while the holding register is full replaces the held character. Only the latest character is sent.
- R10: The control inputs are sampled at the transfer edge. Changing them during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| word_len | input | 2 | Data bit count code (00 to 11 gives 5 to 8) |
| stop_long | input | 1 | 0 gives one stop bit; 1 gives the long stop period |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select, or the inverted stick level |
| par_stick | input | 1 | Send a constant parity level |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Holding register and shift engine both empty |

## Verification
A wrong bit counter or bit index shows up on txd within one bit time (16 clocks). It appears either as a level that is wrong for the bit position or as a bit edge in the wrong cycle. A miscounted stop period shows up at the next frame start or on tx_empty when the frame ends. A holding-register flag that is wrong shows up on hold_empty or tx_empty in the very next cycle. A lost or duplicated character shifts every later frame on the line. Because of these effects, the bench compares all three outputs against a behavioural model on every clock.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers for the UART frame transmitter.
// Assumes frames of 5..8 data bits and a 16x (or other OVERSAMPLE) clock.
package uart_tx_pkg;

    // Phases of the shift engine.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    // Frame shape captured at each transfer.
    typedef struct packed {
        logic [1:0] word_len;
        logic       stop_long;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } line_cfg_t;

    // Stop period in clocks: one bit, one and a half bits, or two bits.
    function automatic int unsigned stop_clocks(input logic stop_long,
                                                input logic short_word,
                                                input int unsigned os);
        if (!stop_long)
            return os;
        else if (short_word)
            return os + os / 2;
        else
            return 2 * os;
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
// One-entry holding register in front of the shift engine.
// A write always wins: it refills the register even while the engine takes
// the old character at the same edge, and it overwrites a held character.
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full
);

    // Tracks occupancy and contents of the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (wr_en) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_tx_parity.sv
// Parity bit generator for the character being transferred.
// Only the data bits that will be sent count toward parity; higher bits are
// masked off according to the word-length code.
module uart_tx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        word_len,
    input  logic              par_even,
    input  logic              par_stick,
    output logic              par_bit
);

    localparam int MIN_BITS = DATA_W - 3;
    localparam int NB_W     = $clog2(DATA_W + 1);

    logic [NB_W-1:0]   nbits;
    logic [DATA_W-1:0] keep;
    logic              ones_odd;

    assign nbits = NB_W'(MIN_BITS) + NB_W'(word_len);

    // Per-bit mask: bit i takes part when it lies inside the word.
    for (genvar i = 0; i < DATA_W; i++) begin : g_keep
        assign keep[i] = (NB_W'(i) < nbits);
    end

    // Picks the parity level from the stick / even decode.
    always_comb begin
        ones_odd = ^(data & keep);
        if (par_stick)
            par_bit = ~par_even;
        else if (par_even)
            par_bit = ones_odd;
        else
            par_bit = ~ones_odd;
    end

endmodule

// File: rtl/uart_tx_shifter.sv
// Shift engine: sequences start, data, parity and stop phases, each bit
// OVERSAMPLE clocks long, with a fractional stop period for short words.
// Assumes load is only raised when idle or in the last stop clock; the frame
// shape is captured at load so later control changes cannot disturb it.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [1:0]        load_word_len,
    input  logic              load_stop_long,
    input  logic              load_par_en,
    input  logic              load_par_bit,
    output logic              busy,
    output logic              last_clk,
    output logic              line
);

    localparam int MIN_BITS  = DATA_W - 3;
    localparam int IDX_W     = $clog2(DATA_W);
    localparam int TICK_W    = $clog2(2 * OVERSAMPLE);
    localparam int BIT_LAST  = OVERSAMPLE - 1;

    tx_state_t         state;
    logic [TICK_W-1:0] tick;
    logic [TICK_W-1:0] tick_last;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  nb_last_q;
    logic [TICK_W-1:0] stop_last_q;
    logic [DATA_W-1:0] sh_q;
    logic              par_q;
    logic              par_en_q;
    logic [TICK_W-1:0] stop_last_d;

    // Stop length chosen from the control word at transfer time.
    always_comb begin
        stop_last_d = TICK_W'(stop_clocks(load_stop_long, (load_word_len == 2'b00),
                                          OVERSAMPLE) - 1);
    end

    // Length of the current bit period.
    always_comb begin
        tick_last = (state == ST_STOP) ? stop_last_q : TICK_W'(BIT_LAST);
    end

    assign busy     = (state != ST_IDLE);
    assign last_clk = (state == ST_STOP) && (tick == stop_last_q);

    // Line level produced by the current phase.
    always_comb begin
        case (state)
            ST_START:  line = 1'b0;
            ST_DATA:   line = sh_q[0];
            ST_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
    end

    // Frame sequencer: captures a character on load and steps the phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            tick        <= '0;
            bit_idx     <= '0;
            nb_last_q   <= '0;
            stop_last_q <= '0;
            sh_q        <= '0;
            par_q       <= 1'b0;
            par_en_q    <= 1'b0;
        end else if (load) begin
            state       <= ST_START;
            tick        <= '0;
            bit_idx     <= '0;
            sh_q        <= load_data;
            par_q       <= load_par_bit;
            par_en_q    <= load_par_en;
            nb_last_q   <= IDX_W'(MIN_BITS - 1) + IDX_W'(load_word_len);
            stop_last_q <= stop_last_d;
        end else if (state != ST_IDLE) begin
            if (tick == tick_last) begin
                tick <= '0;
                case (state)
                    ST_START: begin
                        state   <= ST_DATA;
                        bit_idx <= '0;
                    end
                    ST_DATA: begin
                        sh_q <= sh_q >> 1;
                        if (bit_idx == nb_last_q)
                            state <= par_en_q ? ST_PARITY : ST_STOP;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end
                    ST_PARITY: state <= ST_STOP;
                    default:   state <= ST_IDLE;
                endcase
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_tx_core.sv
// UART frame transmitter top: holding register, parity generator, shift
// engine and break override. Runs on a clock at OVERSAMPLE times the baud.
// Assumes DATA_W is 8 so the word-length code spans 5..8 bits.
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        word_len,
    input  logic              stop_long,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              par_stick,
    input  logic              brk,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);

    line_cfg_t         cfg;
    logic [DATA_W-1:0] hold_data;
    logic              hold_full;
    logic              take;
    logic              busy;
    logic              last_clk;
    logic              line;
    logic              par_bit;

    assign cfg = '{word_len:  word_len,  stop_long: stop_long,
                   par_en:    par_en,    par_even:  par_even,
                   par_stick: par_stick};

    // Transfer whenever the engine is free now or frees up at this edge.
    assign take = hold_full && (!busy || last_clk);

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .hold_full (hold_full)
    );

    uart_tx_parity #(.DATA_W(DATA_W)) u_par (
        .data      (hold_data),
        .word_len  (cfg.word_len),
        .par_even  (cfg.par_even),
        .par_stick (cfg.par_stick),
        .par_bit   (par_bit)
    );

    uart_tx_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk            (clk),
        .rst_n          (rst_n),
        .load           (take),
        .load_data      (hold_data),
        .load_word_len  (cfg.word_len),
        .load_stop_long (cfg.stop_long),
        .load_par_en    (cfg.par_en),
        .load_par_bit   (par_bit),
        .busy           (busy),
        .last_clk       (last_clk),
        .line           (line)
    );

    // Break overrides the frame level without stopping the sequencer.
    assign txd        = brk ? 1'b0 : line;
    assign hold_empty = ~hold_full;
    assign tx_empty   = ~hold_full & ~busy;

endmodule

// File: rtl/uart_tx_core_chk.sv
// Port-level properties of the UART frame transmitter, bound to its top.
module uart_tx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic brk,
    input logic txd,
    input logic hold_empty,
    input logic tx_empty
);

    // R1: reset leaves the block empty and the line high.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (hold_empty && tx_empty && (txd || brk)));

    // R2: with nothing in flight the line idles high.
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !brk) |-> txd);

    // R6: a write fills the holding register.
    assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty);

    // R6: the holding register only fills through a write.
    assert_fill_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_empty) |-> $past(wr_en));

    // R7: break holds the line low.
    assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);

    // R8: fully empty implies the holding register is empty.
    assert_empty_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

endmodule

bind uart_tx_core uart_tx_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .brk        (brk),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty)
);

// File: tb/test_uart_tx_core.sv
// Bench: behavioural per-clock line model compared with the design each cycle.
module test_uart_tx_core;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [1:0] word_len;
    logic       stop_long, par_en, par_even, par_stick, brk;
    logic       txd, hold_empty, tx_empty;

    int    n_checks = 0;
    int    n_bad    = 0;
    string scen     = "R1 reset";
    bit    done     = 1'b0;

    bit    q_lvl[$];
    string q_tag[$];
    bit    m_full;
    bit [7:0] m_data;

    always #2.5 clk = ~clk;

    uart_tx_core i_uart_tx_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .word_len(word_len), .stop_long(stop_long), .par_en(par_en),
        .par_even(par_even), .par_stick(par_stick), .brk(brk),
        .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] got=%b exp=%b at %0t", req, scen, got, exp, $time);
        end
    endtask

    task automatic push_n(input bit lvl, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            q_lvl.push_back(lvl);
            q_tag.push_back(tag);
        end
    endtask

    // Builds the expected per-clock line levels for one frame.
    task automatic build_frame(input bit [7:0] d);
        int nb;
        bit ones;
        bit p;
        nb = 5 + int'(word_len);
        ones = 1'b0;
        push_n(1'b0, 16, "R2");
        for (int b = 0; b < nb; b++) begin
            push_n(d[b], 16, "R3");
            ones ^= d[b];
        end
        if (par_en) begin
            if (par_stick) p = !par_even;
            else           p = par_even ? ones : !ones;
            push_n(p, 16, "R4");
        end
        if (!stop_long)          push_n(1'b1, 16, "R5");
        else if (word_len == 0)  push_n(1'b1, 24, "R5");
        else                     push_n(1'b1, 32, "R5");
    endtask

    // Reference model: advances one clock at each rising edge.
    always @(posedge clk) begin
        bit loaded;
        loaded = 1'b0;
        if (!rst_n) begin
            q_lvl.delete();
            q_tag.delete();
            m_full = 1'b0;
            m_data = '0;
        end else begin
            if (q_lvl.size() > 0) begin
                void'(q_lvl.pop_front());
                void'(q_tag.pop_front());
            end
            if (q_lvl.size() == 0 && m_full) begin
                build_frame(m_data);
                loaded = 1'b1;
            end
            if (wr_en) begin
                m_full = 1'b1;
                m_data = wr_data;
            end else if (loaded) begin
                m_full = 1'b0;
            end
        end
    end

    // Compare all outputs one time unit after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n === 1'b1 && !done) begin
            if (brk)                  chk("R7", txd, 1'b0);
            else if (q_lvl.size() > 0) chk(q_tag[0], txd, q_lvl[0]);
            else                      chk("R2", txd, 1'b1);
            chk("R6", hold_empty, !m_full);
            chk("R8", tx_empty, !m_full && q_lvl.size() == 0);
        end
    end

    task automatic finish_run;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    task automatic send(input bit [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle;
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input int wl, input int pm, input bit sl);
        word_len  = 2'(wl);
        stop_long = sl;
        par_en    = (pm != 0);
        par_even  = (pm == 2) || (pm == 4);
        par_stick = (pm >= 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog [%s] got=hang exp=finish", scen);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; brk = 1'b0;
        set_cfg(3, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R1", txd, 1'b1);
        chk("R1", hold_empty, 1'b1);
        chk("R1", tx_empty, 1'b1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3 R4 R5: every word length, parity mode and stop choice.
        scen = "R3/R4/R5 sweep";
        for (int wl = 0; wl < 4; wl++)
            for (int pm = 0; pm < 5; pm++)
                for (int sl = 0; sl < 2; sl++) begin
                    set_cfg(wl, pm, sl[0]);
                    send(8'hA5 ^ 8'(wl * 37 + pm * 11 + sl * 5));
                    wait_idle();
                end

        // R6: back-to-back frames with no gap.
        scen = "R6 back-to-back";
        set_cfg(1, 2, 1'b0);
        send(8'h3C);
        @(negedge clk);
        while (!hold_empty) @(negedge clk);
        send(8'hC3);
        while (!hold_empty) @(negedge clk);
        send(8'h7E);
        wait_idle();

        // R9: overwrite of a held character.
        scen = "R9 overwrite";
        set_cfg(3, 1, 1'b1);
        send(8'h11);
        repeat (3) @(negedge clk);
        send(8'h22);
        send(8'h33);
        wait_idle();

        // R10: control changes during a frame.
        scen = "R10 mid-frame config";
        set_cfg(3, 2, 1'b0);
        send(8'h5A);
        repeat (20) @(negedge clk);
        set_cfg(0, 3, 1'b1);
        wait_idle();

        // R7: break during a frame and while idle.
        scen = "R7 break";
        set_cfg(2, 4, 1'b0);
        send(8'hF0);
        repeat (40) @(negedge clk);
        brk = 1'b1;
        repeat (30) @(negedge clk);
        brk = 1'b0;
        wait_idle();
        brk = 1'b1;
        repeat (5) @(negedge clk);
        brk = 1'b0;
        repeat (5) @(negedge clk);

        finish_run();
    end

endmodule